// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block decides when an external bus cycle on an asynchronous, 68k-style bus is over. A bus master tells it that a cycle has begun, names the address region the cycle falls in, and says whether the cycle is a read. From then on the controller watches for the event that ends the cycle. That event is one of the following:
- a two-line, active-low size acknowledge from the target;
- an acknowledge it makes itself after a programmed number of wait clocks;
- a fixed two-clock fast completion;
- an active-low bus error;
- a bus monitor timeout.

When the cycle ends, the controller gives one pulse. The pulse carries the port width the target reported, an error flag and a timeout flag. For a read cycle that finished cleanly, a strobe tells the master to capture the read data.

Each region has its own termination mode, wait count and reported port width. The acknowledge and bus error inputs come from outside the clock domain, so each passes through a two-flop synchronizer before it is used. A single shared limit sets the bus monitor. A limit of zero turns the monitor off.

Top module: `bus_term_ctrl`

## Requirements
- R1: While and right after reset, `cyc_busy`, `term_valid` and `latch_data` are low.
- R2: In external mode the acknowledge lines `ack_n[1:0]` are decoded as follows:
  - both low reports a 32-bit port, `term_size` = 2'b00;
  - only `ack_n[1]` low (`ack_n` = 2'b01) reports 16-bit, 2'b10;
  - only `ack_n[0]` low (`ack_n` = 2'b10) reports 8-bit, 2'b01.
- R3: Timing in external mode, with edge 0 being the edge that samples `cyc_start`:
  - if `ack_n` first goes low before edge a (a ≥ 1), `term_valid` is high in the cycle after edge a+2;
  - with no acknowledge, no bus error and the monitor off, the cycle stays busy.
- R4: `latch_data` pulses together with `term_valid` only for a read cycle that ends without error. A write cycle never raises it.
- R5: In internal mode (region mode 2'b01) with wait count W (0 to 15):
  - `term_valid` is high after edge W+2;
  - it reports the region's configured size, with 2'b11 reported as 32-bit (2'b00);
  - `ack_n` is ignored.
- R6: In fast mode (region mode 2'b10), `term_valid` is high after edge 1 with the configured size. The whole access spans two clocks.
- R7: A bus error (`berr_n` low) with no acknowledge in the same sample ends the cycle on the same schedule as R3. It reports `term_error` = 1 and `term_size` = 2'b11, and gives no `latch_data`.
- R8: A bus error sampled together with an external acknowledge ends the cycle with `term_error` = 1 and the decoded port size.
- R9: Bus monitor behaviour:
  - with `bmt_limit` = L > 0 and no other termination, the cycle ends after edge L+1 with `term_error` = 1, `term_timeout` = 1 and `term_size` = 2'b11;
  - L = 0 disables the monitor.
- R10: `term_valid` lasts exactly one clock, and `cyc_busy` is low while it is high.
- R11: A `cyc_start` that arrives while a cycle is in progress is ignored. The running cycle keeps its region and its read/write direction.
- R12: Region r takes its configuration from these fields:
  - mode from `cfg_mode[2r+1:2r]` (2'b00 and 2'b11 mean external);
  - wait count from `cfg_wait[4r+3:4r]`;
  - size from `cfg_size[2r+1:2r]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Begins a bus cycle when idle |
| cyc_region | input | 2 | Region of the starting cycle |
| cyc_read | input | 1 | 1 = read cycle, 0 = write cycle |
| cfg_mode | input | 8 | Per-region termination mode, 2 bits each |
| cfg_wait | input | 16 | Per-region internal wait count, 4 bits each |
| cfg_size | input | 8 | Per-region port size for internal/fast modes |
| bmt_limit | input | 8 | Bus monitor limit in clocks, 0 = off |
| ack_n | input | 2 | Asynchronous active-low size acknowledge |
| berr_n | input | 1 | Asynchronous active-low bus error |
| cyc_busy | output | 1 | A cycle is in progress |
| term_valid | output | 1 | One-clock termination pulse |
| term_size | output | 2 | Reported port size (00=32, 01=8, 10=16, 11=none) |
| term_error | output | 1 | Cycle ended with error |
| term_timeout | output | 1 | Error came from the bus monitor |
| latch_data | output | 1 | Capture read data strobe |

## Verification
The bench measures the exact termination edge in every mode. A design that loses or adds a synchronizer stage, or that is off by one in the wait count, ends the cycle one clock early or late and is flagged.

Several boundary cases each catch a specific fault:
- Wait counts 0 and 15 expose a counter that wraps or compares the wrong width.
- An acknowledge held low during an internal-mode cycle exposes a design that lets external acknowledge leak into internal mode.
- A bus error with and without an acknowledge shows whether the size is reported or suppressed correctly. A design with the priority reversed would report 2'b11 with an acknowledge, or drop the error flag.
- A disabled monitor that times out, and a second start pulse that restarts a running cycle as a fast one, both surface as early terminations.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

    // Port width reported with a termination
    typedef enum logic [1:0] {
        PSZ_32   = 2'b00,
        PSZ_8    = 2'b01,
        PSZ_16   = 2'b10,
        PSZ_NONE = 2'b11
    } port_size_e;

    // Per-region termination source
    typedef enum logic [1:0] {
        TM_EXTERNAL = 2'b00,
        TM_INTERNAL = 2'b01,
        TM_FAST     = 2'b10,
        TM_EXT_ALT  = 2'b11
    } term_mode_e;

    // Synchronized view of the termination inputs
    typedef struct packed {
        logic       ack;
        port_size_e size;
        logic       berr;
    } ack_sample_t;

    // Registered termination report
    typedef struct packed {
        logic       valid;
        port_size_e size;
        logic       error;
        logic       timeout;
        logic       latch;
    } term_result_t;

    // Active-low two-line acknowledge to port width
    function automatic port_size_e decode_ack(input logic [1:0] ack_n);
        case (ack_n)
            2'b00:   return PSZ_32;
            2'b01:   return PSZ_16;
            2'b10:   return PSZ_8;
            default: return PSZ_NONE;
        endcase
    endfunction

    // Configured size for internal/fast modes; the unused code means 32-bit
    function automatic port_size_e cfg_to_size(input logic [1:0] code);
        return (code == 2'b11) ? PSZ_32 : port_size_e'(code);
    endfunction

endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bt_ack_decode.sv
module bt_ack_decode
    import bus_term_pkg::*;
(
    input  logic [1:0]  ack_n_s,
    input  logic        berr_n_s,
    output ack_sample_t smp
);
    always_comb begin
        smp.size = decode_ack(ack_n_s);
        smp.ack  = (smp.size != PSZ_NONE);
        smp.berr = !berr_n_s;
    end
endmodule

// File: rtl/bt_region_cfg.sv
module bt_region_cfg
    import bus_term_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int WS_W        = 4,
    localparam int RGN_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [RGN_W-1:0]            region,
    input  logic [2*NUM_REGIONS-1:0]    cfg_mode,
    input  logic [WS_W*NUM_REGIONS-1:0] cfg_wait,
    input  logic [2*NUM_REGIONS-1:0]    cfg_size,
    output term_mode_e                  sel_mode,
    output logic [WS_W-1:0]             sel_wait,
    output port_size_e                  sel_size
);
    term_mode_e      mode_a [NUM_REGIONS];
    logic [WS_W-1:0] wait_a [NUM_REGIONS];
    port_size_e      size_a [NUM_REGIONS];

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
        assign mode_a[r] = term_mode_e'(cfg_mode[2*r +: 2]);
        assign wait_a[r] = cfg_wait[WS_W*r +: WS_W];
        assign size_a[r] = cfg_to_size(cfg_size[2*r +: 2]);
    end

    always_comb begin
        sel_mode = mode_a[0];
        sel_wait = wait_a[0];
        sel_size = size_a[0];
        for (int r = 1; r < NUM_REGIONS; r++) begin
            if (int'(region) == r) begin
                sel_mode = mode_a[r];
                sel_wait = wait_a[r];
                sel_size = size_a[r];
            end
        end
    end
endmodule

// File: rtl/bt_cycle_fsm.sv
module bt_cycle_fsm
    import bus_term_pkg::*;
#(
    parameter int WS_W   = 4,
    parameter int BMT_W  = 8,
    localparam int CNT_W = (BMT_W > WS_W + 1) ? BMT_W : WS_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_start,
    input  logic            cyc_read,
    input  term_mode_e      sel_mode,
    input  logic [WS_W-1:0] sel_wait,
    input  port_size_e      sel_size,
    input  logic [BMT_W-1:0] bmt_limit,
    input  ack_sample_t     smp,
    output logic            busy,
    output term_result_t    res
);
    term_mode_e      cur_mode;
    logic [WS_W-1:0] cur_wait;
    port_size_e      cur_size;
    logic            cur_read;
    logic [CNT_W-1:0] cnt;

    logic [CNT_W-1:0] wait_tgt, lim;
    logic       ack_hit, tmo_hit, tmo_only, done;
    port_size_e ack_size;

    assign wait_tgt = CNT_W'(cur_wait) + CNT_W'(1);
    assign lim      = CNT_W'(bmt_limit);

    always_comb begin
        case (cur_mode)
            TM_INTERNAL: begin ack_hit = (cnt == wait_tgt); ack_size = cur_size; end
            TM_FAST:     begin ack_hit = (cnt == '0);       ack_size = cur_size; end
            default:     begin ack_hit = smp.ack;           ack_size = smp.size; end
        endcase
        tmo_hit  = (lim != '0) && (cnt == lim);
        tmo_only = tmo_hit && !ack_hit && !smp.berr;
        done     = ack_hit || smp.berr || tmo_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            res      <= '{valid: 1'b0, size: PSZ_NONE, error: 1'b0, timeout: 1'b0, latch: 1'b0};
            cur_mode <= TM_EXTERNAL;
            cur_wait <= '0;
            cur_size <= PSZ_32;
            cur_read <= 1'b0;
            cnt      <= '0;
        end else begin
            res.valid <= 1'b0;
            res.latch <= 1'b0;
            if (!busy) begin
                if (cyc_start) begin
                    busy     <= 1'b1;
                    cnt      <= '0;
                    cur_mode <= sel_mode;
                    cur_wait <= sel_wait;
                    cur_size <= sel_size;
                    cur_read <= cyc_read;
                end
            end else begin
                cnt <= (&cnt) ? cnt : cnt + CNT_W'(1);
                if (done) begin
                    busy        <= 1'b0;
                    res.valid   <= 1'b1;
                    res.size    <= ack_hit ? ack_size : PSZ_NONE;
                    res.error   <= smp.berr || tmo_only;
                    res.timeout <= tmo_only;
                    res.latch   <= cur_read && ack_hit && !smp.berr;
                end
            end
        end
    end

    // Termination is a single-clock pulse, and the block is idle during it
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        res.valid |=> !res.valid);
    assert_idle_at_term_R10: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> !busy);
    // Data capture only on a clean read termination
    assert_latch_clean_R4: assert property (@(posedge clk) disable iff (rst)
        res.latch |-> (res.valid && !res.error));
    // A monitor timeout is an error with no port size
    assert_timeout_error_R9: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.timeout) |-> (res.error && res.size == PSZ_NONE));
    // A report without a port size is always an error
    assert_nosize_error_R7: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.size == PSZ_NONE) |-> res.error);
    // Fast mode terminates on the second edge after acceptance
    assert_fast_two_clk_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && cyc_start && sel_mode == TM_FAST) |=> ##1 res.valid);
    // A start pulse during a cycle does not alter the captured direction
    assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && cur_read == $past(cur_read)));
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
    import bus_term_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int WS_W        = 4,
    parameter int BMT_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int RGN_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cyc_start,
    input  logic [RGN_W-1:0]            cyc_region,
    input  logic                        cyc_read,
    input  logic [2*NUM_REGIONS-1:0]    cfg_mode,
    input  logic [WS_W*NUM_REGIONS-1:0] cfg_wait,
    input  logic [2*NUM_REGIONS-1:0]    cfg_size,
    input  logic [BMT_W-1:0]            bmt_limit,
    input  logic [1:0]                  ack_n,
    input  logic                        berr_n,
    output logic                        cyc_busy,
    output logic                        term_valid,
    output logic [1:0]                  term_size,
    output logic                        term_error,
    output logic                        term_timeout,
    output logic                        latch_data
);
    logic [2:0]      sync_q;
    ack_sample_t     smp;
    term_mode_e      sel_mode;
    logic [WS_W-1:0] sel_wait;
    port_size_e      sel_size;
    term_result_t    res;

    bt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst(rst), .d({berr_n, ack_n}), .q(sync_q)
    );

    bt_ack_decode u_dec (
        .ack_n_s(sync_q[1:0]), .berr_n_s(sync_q[2]), .smp(smp)
    );

    bt_region_cfg #(.NUM_REGIONS(NUM_REGIONS), .WS_W(WS_W)) u_cfg (
        .region(cyc_region), .cfg_mode(cfg_mode), .cfg_wait(cfg_wait),
        .cfg_size(cfg_size), .sel_mode(sel_mode), .sel_wait(sel_wait),
        .sel_size(sel_size)
    );

    bt_cycle_fsm #(.WS_W(WS_W), .BMT_W(BMT_W)) u_fsm (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_read(cyc_read),
        .sel_mode(sel_mode), .sel_wait(sel_wait), .sel_size(sel_size),
        .bmt_limit(bmt_limit), .smp(smp), .busy(cyc_busy), .res(res)
    );

    assign term_valid   = res.valid;
    assign term_size    = res.size;
    assign term_error   = res.error;
    assign term_timeout = res.timeout;
    assign latch_data   = res.latch;
endmodule

// File: tb/bus_term_ctrl_bench.sv
module bus_term_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_start = 1'b0;
    logic [1:0]  cyc_region = '0;
    logic        cyc_read = 1'b0;
    logic [7:0]  cfg_mode;
    logic [15:0] cfg_wait;
    logic [7:0]  cfg_size;
    logic [7:0]  bmt_limit = 8'd200;
    logic [1:0]  ack_n = 2'b11;
    logic        berr_n = 1'b1;
    logic        cyc_busy, term_valid, term_error, term_timeout, latch_data;
    logic [1:0]  term_size;

    localparam logic [1:0] SZ32 = 2'b00, SZ8 = 2'b01, SZ16 = 2'b10, SZNONE = 2'b11;

    int checks = 0;
    int fails  = 0;

    bus_term_ctrl u_bus_term_ctrl (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_region(cyc_region),
        .cyc_read(cyc_read), .cfg_mode(cfg_mode), .cfg_wait(cfg_wait),
        .cfg_size(cfg_size), .bmt_limit(bmt_limit), .ack_n(ack_n), .berr_n(berr_n),
        .cyc_busy(cyc_busy), .term_valid(term_valid), .term_size(term_size),
        .term_error(term_error), .term_timeout(term_timeout), .latch_data(latch_data)
    );

    always #4ns clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Starts a cycle; returns at the falling edge after the sampling edge (edge 0)
    task automatic start_cycle(input logic [1:0] rgn, input logic rd);
        @(negedge clk);
        cyc_start = 1'b1; cyc_region = rgn; cyc_read = rd;
        @(posedge clk);
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Expects the termination pulse after exactly k more edges, then checks it ends
    task automatic wait_term(input string tag, input int k, input logic [1:0] sz,
                             input logic er, input logic to, input logic lt);
        bit early = 0;
        for (int j = 1; j <= k; j++) begin
            @(posedge clk); @(negedge clk);
            if (j < k && term_valid) early = 1;
        end
        check(!early, {tag, " no early termination"}, 32'(early), 0);
        check(term_valid && !cyc_busy, {tag, " termination edge R10"}, {term_valid, cyc_busy}, 2'b10);
        check(term_size == sz, {tag, " size"}, term_size, sz);
        check({term_error, term_timeout} == {er, to}, {tag, " error/timeout"}, {term_error, term_timeout}, {er, to});
        check(latch_data == lt, {tag, " latch R4"}, latch_data, lt);
        @(posedge clk); @(negedge clk);
        check(!term_valid && !latch_data, {tag, " single pulse R10"}, {term_valid, latch_data}, 0);
    endtask

    task automatic t_reset();
        check(!cyc_busy && !term_valid && !latch_data, "R1 during reset", {cyc_busy, term_valid, latch_data}, 0);
        idle(1); rst = 1'b0; idle(1);
        check(!cyc_busy && !term_valid && !latch_data, "R1 after reset", {cyc_busy, term_valid, latch_data}, 0);
    endtask

    task automatic t_ext_sizes();
        start_cycle(2'd0, 1'b1); ack_n = 2'b00;
        wait_term("R2 R3 ack 32", 3, SZ32, 0, 0, 1);
        ack_n = 2'b11; idle(3);
        start_cycle(2'd0, 1'b1); ack_n = 2'b01;
        wait_term("R2 ack 16", 3, SZ16, 0, 0, 1);
        ack_n = 2'b11; idle(3);
        start_cycle(2'd0, 1'b1); ack_n = 2'b10;
        wait_term("R2 ack 8", 3, SZ8, 0, 0, 1);
        ack_n = 2'b11; idle(3);
    endtask

    task automatic t_ext_delay_write();
        start_cycle(2'd0, 1'b0);
        idle(2);
        check(cyc_busy && !term_valid, "R3 waits without ack", {cyc_busy, term_valid}, 2'b10);
        ack_n = 2'b00;
        wait_term("R3 R4 delayed write", 3, SZ32, 0, 0, 0);
        ack_n = 2'b11; idle(3);
    endtask

    task automatic t_internal();
        start_cycle(2'd1, 1'b1);
        wait_term("R5 R12 region1 W3", 5, SZ16, 0, 0, 1);
        idle(1);
        start_cycle(2'd3, 1'b0);
        ack_n = 2'b10;   // must be ignored in internal mode
        wait_term("R5 R12 region3 W0 ack ignored", 2, SZ32, 0, 0, 0);
        ack_n = 2'b11; idle(3);
        cfg_wait[7:4] = 4'd15;
        cfg_size[3:2] = 2'b11;
        start_cycle(2'd1, 1'b1);
        wait_term("R5 W15 size code 11", 17, SZ32, 0, 0, 1);
        cfg_wait[7:4] = 4'd3;
        cfg_size[3:2] = 2'b10;
        idle(1);
    endtask

    task automatic t_fast();
        start_cycle(2'd2, 1'b1);
        wait_term("R6 fast", 1, SZ8, 0, 0, 1);
        idle(1);
    endtask

    task automatic t_berr();
        start_cycle(2'd0, 1'b1); berr_n = 1'b0;
        wait_term("R7 berr alone", 3, SZNONE, 1, 0, 0);
        berr_n = 1'b1; idle(3);
        start_cycle(2'd0, 1'b1); berr_n = 1'b0; ack_n = 2'b00;
        wait_term("R8 berr with ack", 3, SZ32, 1, 0, 0);
        berr_n = 1'b1; ack_n = 2'b11; idle(3);
    endtask

    task automatic t_timeout();
        bmt_limit = 8'd10;
        start_cycle(2'd0, 1'b1);
        wait_term("R9 monitor timeout", 11, SZNONE, 1, 1, 0);
        bmt_limit = 8'd0;
        start_cycle(2'd0, 1'b1);
        idle(60);
        check(cyc_busy && !term_valid, "R9 monitor disabled", {cyc_busy, term_valid}, 2'b10);
        ack_n = 2'b01;
        wait_term("R9 disabled then ack", 3, SZ16, 0, 0, 1);
        ack_n = 2'b11; bmt_limit = 8'd200; idle(3);
    endtask

    task automatic t_busy_start();
        start_cycle(2'd0, 1'b1);
        cyc_start = 1'b1; cyc_region = 2'd2; cyc_read = 1'b0;
        @(posedge clk); @(negedge clk);
        cyc_start = 1'b0;
        ack_n = 2'b01;
        wait_term("R11 start while busy ignored", 3, SZ16, 0, 0, 1);
        ack_n = 2'b11; idle(3);
    endtask

    initial begin
        cfg_mode = {2'b01, 2'b10, 2'b01, 2'b00};
        cfg_wait = {4'd0, 4'd0, 4'd3, 4'd0};
        cfg_size = {2'b00, 2'b01, 2'b10, 2'b00};
        idle(3);
        t_reset();
        t_ext_sizes();
        t_ext_delay_write();
        t_internal();
        t_fast();
        t_berr();
        t_timeout();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule